// File: doc/BRIEF.md
# Saturating Threshold Hit Counter

This block takes, on every input tick, a hit vector from each of eight processing units. Each vector holds one flag for each of sixteen threshold conditions; a condition flag is already the combination of several thresholds made upstream. For every condition the block counts how many units raised that flag. It clamps the count at the largest value a 3-bit field can hold, then packs the sixteen counts into two output words for two separate downstream mergers.

Conditions 0 through 7 form the left word and conditions 8 through 15 form the right word. Each word carries its eight 3-bit counts and one odd-parity bit, 25 bits in all. Each port also has a flag that marks a tick in which one of its counts was clamped. The outputs are registered, update only on a tick, and appear one clock after the tick is presented.

Top module: `hit_mult_counter`

## Requirements
- R1: While reset is asserted and after it is released, until the first tick, valid_o is 0, both saturation flags are 0, and both words are 25'h1000000 (all counts zero, parity bit set).
- R2: The flag of unit u for condition c is at bit u*16+c of hits_i. The count for condition c is the number of units whose flag for c is 1.
- R3: When more than 7 units report condition c, the count for c is 7 and does not wrap.
- R4: Counts of conditions 0..7 appear in left_word_o and counts of conditions 8..15 appear in right_word_o. Condition n of a port (n = c for left, n = c-8 for right) occupies bits [3n+2:3n].
- R5: Bit 24 of each word makes the number of ones in the whole 25-bit word odd.
- R6: left_sat_o (right_sat_o) is 1 exactly when, at the captured tick, at least one of conditions 0..7 (8..15) had more than 7 reporting units.
- R7: A tick presented in the cycle before clock edge k updates the words and flags at edge k. valid_o is 1 for the cycle after each tick edge and 0 otherwise.
- R8: In a cycle without a tick, changes on hits_i have no effect. The words and flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Marks a cycle carrying a new set of hit vectors |
| hits_i | input | 128 | Hit flags, unit u condition c at bit u*16+c |
| left_word_o | output | 25 | Counts of conditions 0..7 plus odd parity |
| right_word_o | output | 25 | Counts of conditions 8..15 plus odd parity |
| left_sat_o | output | 1 | A left-port count was clamped at the last tick |
| right_sat_o | output | 1 | A right-port count was clamped at the last tick |
| valid_o | output | 1 | Words were updated at the last clock edge |

## Verification
Every result is due one rising edge after the tick that carries it. Words, parity, saturation flags and valid all change at that same edge, since only one register stage lies between input and output. The bench drives inputs on the falling edge and lets the next rising edge capture them. It compares all outputs to its own reference model at the falling edge after that, so each comparison sees exactly one capture. Cycles without a tick are compared the same way, with fresh random hits on the input, to show that the outputs hold.

// File: rtl/hmc_pkg.sv
package hmc_pkg;

   // Largest value a count field of the given width can carry
   function automatic int unsigned field_max(input int unsigned width);
      return (1 << width) - 1;
   endfunction

   // Width needed for an unclamped sum of n single-bit votes
   function automatic int unsigned sum_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/hmc_cond_count.sv
module hmc_cond_count
   import hmc_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 8,
   parameter int unsigned CNT_W     = 3
) (
   input  logic [NUM_UNITS-1:0] votes_i,
   output logic [CNT_W-1:0]     count_o,
   output logic                 clip_o
);

   localparam int unsigned CNT_MAX = field_max(CNT_W);
   localparam int unsigned SUM_W0  = sum_width(NUM_UNITS);
   localparam int unsigned RAW_W   = (SUM_W0 > CNT_W) ? SUM_W0 : CNT_W;

   logic [RAW_W-1:0] raw;

   always_comb begin
      raw = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         raw = raw + RAW_W'(votes_i[u]);
      end
   end

   generate
      if (NUM_UNITS > CNT_MAX) begin : g_clamp
         always_comb begin
            if (raw > RAW_W'(CNT_MAX)) begin
               count_o = CNT_W'(CNT_MAX);
               clip_o  = 1'b1;
            end else begin
               count_o = raw[CNT_W-1:0];
               clip_o  = 1'b0;
            end
         end
      end else begin : g_pass
         assign count_o = raw[CNT_W-1:0];
         assign clip_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hmc_port_pack.sv
module hmc_port_pack #(
   parameter int unsigned LANES = 8,
   parameter int unsigned CNT_W = 3
) (
   input  logic [LANES*CNT_W-1:0] counts_i,
   input  logic [LANES-1:0]       clips_i,
   output logic [LANES*CNT_W:0]   word_o,
   output logic                   sat_o
);

   logic par_bit;

   // odd parity: total ones across data plus parity is odd
   assign par_bit = ~(^counts_i);
   assign word_o  = {par_bit, counts_i};
   assign sat_o   = |clips_i;

endmodule

// File: rtl/hit_mult_counter.sv
module hit_mult_counter
   import hmc_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 8,
   parameter int unsigned NUM_COND  = 16,
   parameter int unsigned CNT_W     = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick_i,
   input  logic [NUM_UNITS*NUM_COND-1:0]   hits_i,
   output logic [(NUM_COND/2)*CNT_W:0]     left_word_o,
   output logic [(NUM_COND/2)*CNT_W:0]     right_word_o,
   output logic                            left_sat_o,
   output logic                            right_sat_o,
   output logic                            valid_o
);

   localparam int unsigned LANES   = NUM_COND / 2;
   localparam int unsigned WORD_W  = LANES * CNT_W + 1;
   localparam int unsigned CNT_MAX = field_max(CNT_W);
   localparam int unsigned NPORT   = 2;
   localparam logic [WORD_W-1:0] IDLE_WORD = {1'b1, {(WORD_W-1){1'b0}}};

   // elaboration-time parameter checks
   generate
      if (NUM_COND % 2 != 0 || NUM_COND < 2) begin : g_bad_cond
         $error("hit_mult_counter: NUM_COND must be even and at least 2");
      end
      if (NUM_UNITS < 1) begin : g_bad_units
         $error("hit_mult_counter: NUM_UNITS must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("hit_mult_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [NUM_UNITS-1:0]   votes  [NUM_COND];
   logic [CNT_W-1:0]       counts [NUM_COND];
   logic [NUM_COND-1:0]    clips;
   logic [WORD_W-1:0]      word_n [NPORT];
   logic                   sat_n  [NPORT];
   logic [WORD_W-1:0]      word_q [NPORT];
   logic                   sat_q  [NPORT];
   logic                   valid_q;

   // regroup unit-major hit bus into condition-major vote vectors
   generate
      for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
         for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign votes[c][u] = hits_i[u*NUM_COND + c];
         end
         hmc_cond_count #(
            .NUM_UNITS (NUM_UNITS),
            .CNT_W     (CNT_W)
         ) count_i (
            .votes_i (votes[c]),
            .count_o (counts[c]),
            .clip_o  (clips[c])
         );
      end
   endgenerate

   // pack and register each destination port
   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         logic [LANES*CNT_W-1:0] lane_bus;
         for (genvar n = 0; n < LANES; n++) begin : g_lane
            assign lane_bus[n*CNT_W +: CNT_W] = counts[p*LANES + n];
         end

         hmc_port_pack #(
            .LANES (LANES),
            .CNT_W (CNT_W)
         ) pack_i (
            .counts_i (lane_bus),
            .clips_i  (clips[p*LANES +: LANES]),
            .word_o   (word_n[p]),
            .sat_o    (sat_n[p])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q[p] <= IDLE_WORD;
               sat_q[p]  <= 1'b0;
            end else if (tick_i) begin
               word_q[p] <= word_n[p];
               sat_q[p]  <= sat_n[p];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= tick_i;
      end
   end

   assign left_word_o  = word_q[0];
   assign right_word_o = word_q[1];
   assign left_sat_o   = sat_q[0];
   assign right_sat_o  = sat_q[1];
   assign valid_o      = valid_q;

   // R7
   valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> valid_o);

   // R7
   no_valid_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> !valid_o);

   // R8
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(left_word_o) && $stable(right_word_o)
                  && $stable(left_sat_o) && $stable(right_sat_o));

   // R5
   left_odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(left_word_o) % 2) == 1);

   // R5
   right_odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(right_word_o) % 2) == 1);

   // R3
   first_lane_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && ($countones(votes[0]) >= CNT_MAX)
      |=> left_word_o[CNT_W-1:0] == CNT_W'(CNT_MAX));

   // R6
   left_sat_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && ($countones(votes[0]) > CNT_MAX) |=> left_sat_o);

   // R6
   right_sat_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && ($countones(votes[NUM_COND-1]) > CNT_MAX) |=> right_sat_o);

endmodule

// File: tb/hit_mult_counter_tb.sv
`timescale 1ns/1ps
module hit_mult_counter_tb_top;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic [127:0]  hits_i = '0;
   logic [24:0]   left_word_o, right_word_o;
   logic          left_sat_o, right_sat_o, valid_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [24:0] exp_left  = 25'h1000000;
   logic [24:0] exp_right = 25'h1000000;
   logic        exp_lsat  = 1'b0;
   logic        exp_rsat  = 1'b0;
   logic        exp_valid = 1'b0;

   always #2 clk = ~clk;

   hit_mult_counter dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .hits_i       (hits_i),
      .left_word_o  (left_word_o),
      .right_word_o (right_word_o),
      .left_sat_o   (left_sat_o),
      .right_sat_o  (right_sat_o),
      .valid_o      (valid_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model: what one tick of hits should produce
   task automatic model(input logic [127:0] h);
      int n;
      logic [23:0] ld, rd;
      ld = '0; rd = '0;
      exp_lsat = 1'b0; exp_rsat = 1'b0;
      for (int c = 0; c < 16; c++) begin
         n = 0;
         for (int u = 0; u < 8; u++) n += h[u*16 + c];
         if (c < 8) begin
            if (n > 7) exp_lsat = 1'b1;
            ld[c*3 +: 3] = (n > 7) ? 3'd7 : 3'(n);
         end else begin
            if (n > 7) exp_rsat = 1'b1;
            rd[(c-8)*3 +: 3] = (n > 7) ? 3'd7 : 3'(n);
         end
      end
      exp_left  = {~(^ld), ld};
      exp_right = {~(^rd), rd};
   endtask

   task automatic compare_all(input bit hold_cycle);
      string t;
      t = hold_cycle ? "R8 hold" : "R2/R4";
      chk({t, " left word counts"},  32'(left_word_o[23:0]),  32'(exp_left[23:0]));
      chk({t, " right word counts"}, 32'(right_word_o[23:0]), 32'(exp_right[23:0]));
      chk("R5 left parity",  32'(left_word_o[24]),  32'(exp_left[24]));
      chk("R5 right parity", 32'(right_word_o[24]), 32'(exp_right[24]));
      chk(hold_cycle ? "R8 left sat hold" : "R6 left sat",  32'(left_sat_o),  32'(exp_lsat));
      chk(hold_cycle ? "R8 right sat hold" : "R6 right sat", 32'(right_sat_o), 32'(exp_rsat));
      chk("R7 valid", 32'(valid_o), 32'(exp_valid));
   endtask

   // called at a falling edge: drive, let the rising edge capture, compare
   task automatic step(input bit tk, input logic [127:0] h);
      tick_i = tk;
      hits_i = h;
      if (tk) model(h);
      exp_valid = tk;
      @(negedge clk);
      compare_all(!tk);
   endtask

   function automatic logic [127:0] cond_pattern(input int c, input int k);
      logic [127:0] r;
      r = '0;
      for (int u = 0; u < 8; u++) if (u < k) r[u*16 + c] = 1'b1;
      return r;
   endfunction

   initial begin
      logic [127:0] h;
      repeat (3) @(negedge clk);
      // R1 values during reset
      chk("R1 left word in reset",  32'(left_word_o),  32'h1000000);
      chk("R1 right word in reset", 32'(right_word_o), 32'h1000000);
      chk("R1 sat flags in reset",  32'({left_sat_o, right_sat_o}), 32'h0);
      chk("R1 valid in reset",      32'(valid_o), 32'h0);
      rst_n = 1'b1;
      // R1 idle after release, with garbage on hits and no tick
      step(1'b0, {4{32'hdeadbeef}});

      // all zero
      step(1'b1, '0);
      // all ones: every count clamps (R3)
      step(1'b1, '1);
      chk("R3 count clamps at 7", 32'(left_word_o[2:0]), 32'd7);
      chk("R3 right count clamps at 7", 32'(right_word_o[23:21]), 32'd7);
      // single unit, all conditions
      step(1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_ffff);
      // each condition alone with k = 0..8 units
      for (int c = 0; c < 16; c++) begin
         for (int k = 0; k <= 8; k++) step(1'b1, cond_pattern(c, k));
      end
      // exactly 7 units everywhere: no saturation flag
      step(1'b1, {16'h0, {7{16'hffff}}});
      // only a right condition at 8, left untouched (R6 per port)
      step(1'b1, cond_pattern(12, 8));
      // R8: ticks off while hits change
      for (int i = 0; i < 6; i++) step(1'b0, {$urandom, $urandom, $urandom, $urandom});
      // back-to-back ticks then gaps, random patterns biased toward saturation
      for (int i = 0; i < 400; i++) begin
         h = {$urandom, $urandom, $urandom, $urandom};
         if (i % 3 == 0) h = h | {$urandom, $urandom, $urandom, $urandom};
         step(($urandom % 4) != 0, h);
      end
      // reset again mid-run (R1)
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_left = 25'h1000000; exp_right = 25'h1000000;
      exp_lsat = 1'b0; exp_rsat = 1'b0; exp_valid = 1'b0;
      step(1'b0, '1);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule